// File: doc/BRIEF.md
# Parallel Flash Byte Programming Controller

This block is the controller side of a parallel programming port for a byte-wide code memory. An external programmer presents an address, a data byte and an operation code, holds the programming-voltage-valid flag high, and pulses a program strobe. The controller then runs a self-timed byte write, a chip erase or a lock-bit programming cycle against its internal array, and holds busy high for the whole cycle. A verify operation needs no strobe. While the verify code is applied, the stored byte at the addressed location appears on the data output one cycle later.

The array has no auto-erase. A byte write can only clear bits, so the stored value becomes the old value ANDed with the new data. A location that is not blank therefore needs a chip erase before it can take an arbitrary value. The only way back to the blank state (all bytes 0xFF) is a chip erase, and the erase also clears the lock-bit outputs. Write-inhibit and verify-inhibit inputs come from a separate lock unit.

`MEM_BYTES` sets the array size. A full-size instance uses 12288, which covers 0x0000 to 0x2FFF. The default is smaller so that the flop array stays small. Operation codes: 4'h1 byte write, 4'h2 verify, 4'h3 chip erase, 4'h4 lock program. Any other code is not a valid strobed operation.

Top module: `pflash_prog_ctrl`

## Requirements
- R1: After reset: busy_o=0, data_o=0x00, lock_o=0, err_o=0 and ovr_o=0.
- R2: A byte write starts on a strobe rising edge when four conditions hold: op_i=4'h1, vpp_ok_i=1, the address is below MEM_BYTES and wr_inhibit_i=0. busy_o rises at the next clock and stays high for exactly WR_CYCLES cycles. The stored byte changes at the edge where busy_o falls.
- R3: A byte write stores old AND data_i, so it can clear bits but never set them.
- R4: On a strobe with op_i=4'h3 and vpp_ok_i=1, the chip erase holds busy_o for exactly ER_CYCLES cycles. At the end, every byte reads 0xFF and lock_o is 0.
- R5: data_o is registered. One cycle after op_i=4'h2 is applied, it shows the stored byte at addr_i, provided that vpp_ok_i=1, busy_o=0, vfy_inhibit_i=0 and the address is below MEM_BYTES. In every other case it shows 0x00.
- R6: A strobe while vpp_ok_i=0 starts nothing and sets err_o. If vpp_ok_i falls during a cycle, the cycle aborts: busy_o drops, nothing is committed and err_o is set.
- R7: A byte write to an address at or above MEM_BYTES is rejected. busy_o stays low, memory is unchanged and err_o is set.
- R8: While wr_inhibit_i=1, a byte-write strobe is dropped. busy_o stays low, memory is unchanged and err_o is set.
- R9: A strobe that arrives while busy_o=1 is ignored and sets ovr_o. The running cycle completes unchanged.
- R10: A lock-program cycle (op_i=4'h4) takes WR_CYCLES cycles. It then ORs data_i[2:0] into lock_o, where a 1 means programmed. wr_inhibit_i does not block it.
- R11: A strobe taken while idle sets err_o to 1 if it is rejected (this includes any code other than 4'h1, 4'h3 and 4'h4) and to 0 otherwise. It also clears ovr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 14 | Byte address |
| data_i | input | 8 | Write data / lock-bit mask |
| op_i | input | 4 | Operation code |
| vpp_ok_i | input | 1 | Programming voltage valid |
| prog_strobe_i | input | 1 | Program strobe, acts on its rising edge |
| wr_inhibit_i | input | 1 | Blocks byte writes |
| vfy_inhibit_i | input | 1 | Blocks verify reads |
| data_o | output | 8 | Verify read data |
| busy_o | output | 1 | Self-timed cycle running |
| err_o | output | 1 | Last request rejected or aborted |
| ovr_o | output | 1 | Strobe arrived while busy |
| lock_o | output | 3 | Programmed lock bits |

## Verification
The strobe is registered once to find its edge, so a request accepted at clock edge k raises busy_o at edge k and drops it at edge k+WR_CYCLES (or k+ER_CYCLES for an erase). err_o and ovr_o settle at that same edge k. The stored byte changes at the edge where busy_o falls. The bench drives and samples on falling edges. It counts the falling edges that see busy_o high, which must equal the cycle length exactly. It reads the flags on the first falling edge after the strobe. A verify result is read one falling edge after the verify code is applied, which matches the single output register.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  typedef enum logic [3:0] {
    OP_NONE   = 4'h0,
    OP_WRITE  = 4'h1,
    OP_VERIFY = 4'h2,
    OP_ERASE  = 4'h3,
    OP_LOCK   = 4'h4
  } op_e;
endpackage

// File: rtl/pfp_array.sv
module pfp_array #(
  parameter int DATA_W    = 8,
  parameter int MEM_BYTES = 1024,
  localparam int IDX_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              erase_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [MEM_BYTES];

  // Storage cells carry no reset; erase is the only way to blank them.
  always_ff @(posedge clk) begin
    if (erase_i) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '1;
    end else if (we_i) begin
      mem[widx_i] <= mem[widx_i] & wdata_i;
    end
  end

  assign rdata_o = mem[ridx_i];

  // R3: a write never sets a bit that was clear
  a_r3_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !erase_i) |=> ((mem[$past(widx_i)] & ~$past(mem[widx_i])) == '0));

  // R4: erase leaves cells blank
  a_r4_erase_blank: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (mem[0] == '1 && mem[MEM_BYTES-1] == '1));
endmodule

// File: rtl/pfp_seq.sv
module pfp_seq
  import pfp_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1000,
  parameter int ER_CYCLES = 2000,
  localparam int MAXC     = (WR_CYCLES > ER_CYCLES) ? WR_CYCLES : ER_CYCLES,
  localparam int CNT_W    = $clog2(MAXC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              addr_ok_i,
  input  logic              vpp_ok_i,
  input  logic              wr_inhibit_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              ovr_o,
  output logic              commit_wr_o,
  output logic              commit_er_o,
  output logic              commit_lk_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  logic              busy_q, busy_d, err_q, err_d, ovr_q, ovr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [3:0]        kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ok;
  logic [CNT_W-1:0]  len;
  logic              done;

  always_comb begin
    ok  = 1'b0;
    len = CNT_W'(WR_CYCLES - 1);
    case (op_i)
      OP_WRITE: ok = vpp_ok_i && addr_ok_i && !wr_inhibit_i;
      OP_ERASE: begin ok = vpp_ok_i; len = CNT_W'(ER_CYCLES - 1); end
      OP_LOCK:  ok = vpp_ok_i;
      default:  ok = 1'b0;
    endcase
  end

  assign done = busy_q && vpp_ok_i && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q; err_d = err_q; ovr_d = ovr_q;
    cnt_d  = cnt_q;  kind_d = kind_q; addr_d = addr_q; data_d = data_q;
    if (busy_q) begin
      if (start_i) ovr_d = 1'b1;
      if (!vpp_ok_i) begin
        busy_d = 1'b0;
        err_d  = 1'b1;
      end else if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start_i) begin
      ovr_d = 1'b0;
      err_d = !ok;
      if (ok) begin
        busy_d = 1'b1;
        cnt_d  = len;
        kind_d = op_i;
        addr_d = addr_i;
        data_d = data_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; err_q <= 1'b0; ovr_q <= 1'b0;
      cnt_q  <= '0;   kind_q <= OP_NONE; addr_q <= '0; data_q <= '0;
    end else begin
      busy_q <= busy_d; err_q <= err_d; ovr_q <= ovr_d;
      cnt_q  <= cnt_d;  kind_q <= kind_d; addr_q <= addr_d; data_q <= data_d;
    end
  end

  assign busy_o      = busy_q;
  assign err_o       = err_q;
  assign ovr_o       = ovr_q;
  assign commit_wr_o = done && (kind_q == OP_WRITE);
  assign commit_er_o = done && (kind_q == OP_ERASE);
  assign commit_lk_o = done && (kind_q == OP_LOCK);
  assign cmd_addr_o  = addr_q;
  assign cmd_data_o  = data_q;

  // R9: strobe during a cycle flags an overrun
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ovr_q);

  // R2: a cycle ends only when its timer is spent or the voltage is lost
  a_r2_timed_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == '0 || !$past(vpp_ok_i)));

  // R6: losing the voltage mid-cycle flags an error
  a_r6_abort_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !vpp_ok_i) |=> (!busy_q && err_q));
endmodule

// File: rtl/pflash_prog_ctrl.sv
module pflash_prog_ctrl
  import pfp_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int MEM_BYTES = 1024,
  parameter int LOCK_W    = 3,
  parameter int WR_CYCLES = 1000,
  parameter int ER_CYCLES = 2000,
  localparam int IDX_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [3:0]        op_i,
  input  logic              vpp_ok_i,
  input  logic              prog_strobe_i,
  input  logic              wr_inhibit_i,
  input  logic              vfy_inhibit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              ovr_o,
  output logic [LOCK_W-1:0] lock_o
);
  logic              strb_q, strb_rise, addr_ok, vfy_ok;
  logic              c_wr, c_er, c_lk;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data, rdata, dout_d, dout_q;
  logic [LOCK_W-1:0] lock_d, lock_q;

  assign strb_rise = prog_strobe_i && !strb_q;
  assign addr_ok   = ({1'b0, addr_i} < (ADDR_W + 1)'(MEM_BYTES));

  pfp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WR_CYCLES(WR_CYCLES), .ER_CYCLES(ER_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(strb_rise), .op_i(op_i),
    .addr_i(addr_i), .data_i(data_i), .addr_ok_i(addr_ok),
    .vpp_ok_i(vpp_ok_i), .wr_inhibit_i(wr_inhibit_i),
    .busy_o(busy_o), .err_o(err_o), .ovr_o(ovr_o),
    .commit_wr_o(c_wr), .commit_er_o(c_er), .commit_lk_o(c_lk),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  pfp_array #(.DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .we_i(c_wr), .erase_i(c_er),
    .widx_i(cmd_addr[IDX_W-1:0]), .wdata_i(cmd_data),
    .ridx_i(addr_i[IDX_W-1:0]), .rdata_o(rdata)
  );

  always_comb begin
    vfy_ok = (op_i == OP_VERIFY) && vpp_ok_i && !busy_o && !vfy_inhibit_i && addr_ok;
    dout_d = vfy_ok ? rdata : '0;
    lock_d = lock_q;
    if (c_er)      lock_d = '0;
    else if (c_lk) lock_d = lock_q | cmd_data[LOCK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      dout_q <= '0;
      lock_q <= '0;
    end else begin
      strb_q <= prog_strobe_i;
      dout_q <= dout_d;
      lock_q <= lock_d;
    end
  end

  assign data_o = dout_q;
  assign lock_o = lock_q;

  // R8: an inhibited write request never starts a cycle
  a_r8_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_rise && !busy_o && op_i == OP_WRITE && wr_inhibit_i) |=> (!busy_o && err_o));

  // R6: a cycle only starts with the programming voltage present
  a_r6_vpp_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(vpp_ok_i));

  // R10: lock programming never clears a programmed lock bit
  a_r10_lock_mono: assert property (@(posedge clk) disable iff (!rst_n)
    c_lk |=> ((lock_o & $past(lock_o)) == $past(lock_o)));

  // R5: verify output is blank when a cycle is running
  a_r5_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (data_o == '0));
endmodule

// File: tb/pflash_prog_ctrl_test.sv
module pflash_prog_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WR = 5;
  localparam int ER = 8;
  localparam int NB = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [3:0]  op_i = '0;
  logic        vpp_ok_i = 1'b1;
  logic        prog_strobe_i = 1'b0;
  logic        wr_inhibit_i = 1'b0;
  logic        vfy_inhibit_i = 1'b0;
  logic [7:0]  data_o;
  logic        busy_o, err_o, ovr_o;
  logic [2:0]  lock_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int bcnt;

  pflash_prog_ctrl #(.MEM_BYTES(NB), .WR_CYCLES(WR), .ER_CYCLES(ER)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i), .op_i(op_i),
    .vpp_ok_i(vpp_ok_i), .prog_strobe_i(prog_strobe_i),
    .wr_inhibit_i(wr_inhibit_i), .vfy_inhibit_i(vfy_inhibit_i),
    .data_o(data_o), .busy_o(busy_o), .err_o(err_o), .ovr_o(ovr_o), .lock_o(lock_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {addr, write data, expected readback}
  localparam logic [29:0] VEC [6] = '{
    {14'h000, 8'hA5, 8'hA5},
    {14'h3FF, 8'h3C, 8'h3C},
    {14'h000, 8'h0F, 8'h05},
    {14'h123, 8'hFF, 8'hFF},
    {14'h123, 8'hF0, 8'hF0},
    {14'h123, 8'h3F, 8'h30}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] op, input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    op_i = op; addr_i = a; data_i = d; prog_strobe_i = 1'b1;
    @(negedge clk);
    prog_strobe_i = 1'b0;
  endtask

  task automatic wait_idle();
    bcnt = 0;
    while (busy_o) begin
      bcnt++;
      @(negedge clk);
    end
    op_i = 4'h0;
  endtask

  task automatic verify(input logic [13:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    op_i = 4'h2; addr_i = a;
    @(negedge clk);
    chk(req, data_o, exp);
    op_i = 4'h0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 data", data_o, 0);
    chk("R1 lock", lock_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 ovr", ovr_o, 0);

    // R4: erase timing and blank contents
    strobe(4'h3, 14'h0, 8'h0);
    wait_idle();
    chk("R4 erase length", bcnt, ER);
    verify(14'h000, 8'hFF, "R4 blank low");
    verify(14'h3FF, 8'hFF, "R4 blank high");

    // R2 R3 R5 vector walk
    for (int i = 0; i < 6; i++) begin
      strobe(4'h1, VEC[i][29:16], VEC[i][15:8]);
      wait_idle();
      chk("R2 write length", bcnt, WR);
      chk("R11 err clear", err_o, 0);
      verify(VEC[i][29:16], VEC[i][7:0], "R3/R5 readback");
    end

    // R7 out of range
    strobe(4'h1, 14'h400, 8'h00);
    chk("R7 err", err_o, 1);
    wait_idle();
    chk("R7 no cycle", bcnt, 0);
    verify(14'h400, 8'h00, "R5 out of range verify");
    strobe(4'h1, 14'h3000, 8'h00);
    chk("R7 err top", err_o, 1);
    verify(14'h000, 8'h05, "R7 alias untouched");

    // R8 write inhibit
    wr_inhibit_i = 1'b1;
    strobe(4'h1, 14'h200, 8'h00);
    chk("R8 err", err_o, 1);
    wait_idle();
    chk("R8 no cycle", bcnt, 0);
    wr_inhibit_i = 1'b0;
    verify(14'h200, 8'hFF, "R8 unchanged");

    // R6 voltage absent at strobe
    vpp_ok_i = 1'b0;
    strobe(4'h1, 14'h201, 8'h00);
    chk("R6 err", err_o, 1);
    chk("R6 no busy", busy_o, 0);
    vpp_ok_i = 1'b1;
    verify(14'h201, 8'hFF, "R6 unchanged");

    // R6 voltage lost mid-cycle
    strobe(4'h1, 14'h202, 8'h11);
    chk("R6 busy started", busy_o, 1);
    @(negedge clk);
    vpp_ok_i = 1'b0;
    @(negedge clk);
    vpp_ok_i = 1'b1;
    chk("R6 abort busy", busy_o, 0);
    chk("R6 abort err", err_o, 1);
    repeat (WR) @(negedge clk);
    verify(14'h202, 8'hFF, "R6 abort no commit");

    // R9 overrun
    strobe(4'h1, 14'h203, 8'h5A);
    strobe(4'h1, 14'h204, 8'h00);
    chk("R9 ovr", ovr_o, 1);
    chk("R9 still busy", busy_o, 1);
    wait_idle();
    chk("R9 original length", bcnt, WR - 2);
    verify(14'h203, 8'h5A, "R9 first completes");
    verify(14'h204, 8'hFF, "R9 second ignored");
    strobe(4'h1, 14'h205, 8'h77);
    chk("R11 ovr clear", ovr_o, 0);
    wait_idle();

    // R5 verify inhibit
    vfy_inhibit_i = 1'b1;
    verify(14'h203, 8'h00, "R5 inhibited");
    vfy_inhibit_i = 1'b0;

    // R10 lock bits, unaffected by write inhibit
    wr_inhibit_i = 1'b1;
    strobe(4'h4, 14'h0, 8'h05);
    wait_idle();
    chk("R10 length", bcnt, WR);
    chk("R10 lock", lock_o, 3'b101);
    strobe(4'h4, 14'h0, 8'h02);
    wait_idle();
    chk("R10 lock or", lock_o, 3'b111);
    wr_inhibit_i = 1'b0;

    // R11 unknown code
    strobe(4'hE, 14'h0, 8'h00);
    chk("R11 bad op err", err_o, 1);
    chk("R11 bad op idle", busy_o, 0);

    // R4 erase clears locks and data
    strobe(4'h3, 14'h0, 8'h0);
    wait_idle();
    chk("R4 lock cleared", lock_o, 0);
    verify(14'h203, 8'hFF, "R4 data blank");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule